// File: doc/BRIEF.md
# NOR Flash Erase Sequencer

This block drives the bus of a parallel NOR flash device and carries out a complete erase without software help. A one-cycle start pulse, together with an operation select, begins either a whole-device erase or the erase of one sector. For a sector erase the caller also supplies the sector address. The block then issues the six-write JEDEC erase command sequence through a simple bus-cycle engine. That engine holds address and data steady around a centred write-enable window, and it pulses read-enable for reads.

Once the command has been accepted, the block polls the device's status bits. It reads the same location again and again and compares bit 6 of each read with bit 6 of the read before it. When that bit stops toggling, the erase is over. If the device raises its timeout flag on bit 5 while bit 6 is still toggling, the block takes one more pair of reads before it declares failure. It ends every operation with a one-cycle done pulse and an 8-bit status.

Top module: `nor_erase_seq`

## Requirements
- R1: After synchronous reset, busy, done, flash_we and flash_re are all low, and status reads 0x00.
- R2: Both operations open with five writes in this exact sequence: data 0xAA at address 0x5555, 0x55 at 0x2AAA, 0x80 at 0x5555, 0xAA at 0x5555, and 0x55 at 0x2AAA.
- R3: With op_sector = 0 (whole device), the sixth write is 0x10 at address 0x5555.
- R4: With op_sector = 1, the sixth write is 0x30 at the sector_addr value captured with the start pulse.
- R5: Each write holds address and data for WR_CYC cycles. flash_we is high only in the interior WR_CYC-2 cycles of that window, so it drops between consecutive writes.
- R6: Each read holds flash_re high for RD_CYC cycles with a steady address and samples flash_rdata on the last of them. flash_we and flash_re are never high together.
- R7: Status reads use address 0x5555 for a whole-device erase and the captured sector address for a sector erase.
- R8: Polling compares bit 6 of each status read with bit 6 of the read before it. Equal bits end the operation with status 0x00. Bit 5 is examined only on a read whose bit 6 differs from the previous read.
- R9: When a toggling read has bit 5 set, exactly two further reads follow. The status is 0x00 if bit 6 agrees between those two reads and 0xFF otherwise.
- R10: busy rises in the cycle after an accepted start. done is a single-cycle pulse in the cycle busy falls, and status at done is 0x00 or 0xFF and holds until the next operation.
- R11: A start pulse that arrives while busy is high has no effect on the bus sequence, the operation select or the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin an erase |
| op_sector | input | 1 | 0: whole-device erase, 1: sector erase |
| sector_addr | input | ADDR_W | Sector address, captured with start |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| status | output | 8 | 0x00 pass, 0xFF fail or timeout |
| flash_addr | output | ADDR_W | Flash address bus |
| flash_wdata | output | 8 | Flash write data |
| flash_we | output | 1 | Flash write enable, active high |
| flash_re | output | 1 | Flash read enable, active high |
| flash_rdata | input | 8 | Flash read data |

## Verification
A wrong sequencer state or step count shows up at once on the bus: a write lands at the wrong address or with the wrong data within one write window, or the number of status reads differs from the count expected for the device's toggle and timeout behaviour. A wrong comparison register changes the number of reads and the final status. An engine-timing fault shows up as a write-enable or read-enable pulse of the wrong length, or as a moving address inside a window, within the transaction where it happens. The bench sweeps the device's toggle length, the point where it raises its timeout flag and its steady-state bit 5 for both operations, and checks the full bus trace of every run.

// File: rtl/nor_erase_pkg.sv
// Shared types and command constants for the NOR erase sequencer.
// Assumes 8-bit flash data and an address bus of at least 15 bits.
package nor_erase_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,    // waiting for start
        ST_CMD,     // issuing the six command writes
        ST_PFIRST,  // first status read (reference value)
        ST_POLL,    // sliding status reads
        ST_RCHK_A,  // first read after a timeout flag
        ST_RCHK_B   // second read after a timeout flag
    } seq_state_t;

    localparam logic [15:0] KEY_ADDR_A = 16'h5555;
    localparam logic [15:0] KEY_ADDR_B = 16'h2AAA;
    localparam logic [7:0]  KEY_DATA_A = 8'hAA;
    localparam logic [7:0]  KEY_DATA_B = 8'h55;
    localparam logic [7:0]  CMD_SETUP  = 8'h80;
    localparam logic [7:0]  CMD_WHOLE  = 8'h10;
    localparam logic [7:0]  CMD_SECTOR = 8'h30;
    localparam logic [7:0]  ST_PASS    = 8'h00;
    localparam logic [7:0]  ST_FAIL    = 8'hFF;
    localparam int          TOGGLE_BIT = 6;
    localparam int          TMO_BIT    = 5;
    localparam int          NUM_STEPS  = 6;

endpackage

// File: rtl/nor_cmd_table.sv
// Command table: maps a step index (0..5) and the operation kind to the
// address and data of that write. Purely combinational.
// Assumes ADDR_W >= 16 bits or that the key addresses fit in ADDR_W.
module nor_cmd_table
    import nor_erase_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic [2:0]        step,
    input  logic              is_sector,
    input  logic [ADDR_W-1:0] sec_addr,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [7:0]        cmd_data
);

    localparam logic [ADDR_W-1:0] A_KEY1 = ADDR_W'(KEY_ADDR_A);
    localparam logic [ADDR_W-1:0] A_KEY2 = ADDR_W'(KEY_ADDR_B);

    // Select the write for the current step.
    always_comb begin
        unique case (step)
            3'd0:    begin cmd_addr = A_KEY1; cmd_data = KEY_DATA_A; end
            3'd1:    begin cmd_addr = A_KEY2; cmd_data = KEY_DATA_B; end
            3'd2:    begin cmd_addr = A_KEY1; cmd_data = CMD_SETUP;  end
            3'd3:    begin cmd_addr = A_KEY1; cmd_data = KEY_DATA_A; end
            3'd4:    begin cmd_addr = A_KEY2; cmd_data = KEY_DATA_B; end
            default: begin
                cmd_addr = is_sector ? sec_addr : A_KEY1;
                cmd_data = is_sector ? CMD_SECTOR : CMD_WHOLE;
            end
        endcase
    end

endmodule

// File: rtl/nor_bus_cycle.sv
// Bus-cycle engine: runs one flash write or read per request.
// Write: address/data held WR_CYC cycles, write enable in interior cycles.
// Read: read enable for RD_CYC cycles, data sampled on the last one.
// Assumes WR_CYC >= 3 and RD_CYC >= 1; a request is taken only when idle.
module nor_bus_cycle #(
    parameter int ADDR_W = 18,
    parameter int WR_CYC = 4,
    parameter int RD_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_data,
    output logic              fin,
    output logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        bus_wdata,
    output logic              bus_we,
    output logic              bus_re,
    input  logic [7:0]        bus_rdata
);

    localparam int LONGEST = (WR_CYC > RD_CYC) ? WR_CYC : RD_CYC;
    localparam int CW      = $clog2(LONGEST) + 1;
    localparam logic [CW-1:0] WR_LAST = CW'(WR_CYC - 1);
    localparam logic [CW-1:0] RD_LAST = CW'(RD_CYC - 1);

    logic              act;
    logic              wr_q;
    logic [CW-1:0]     cnt;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        data_q;
    logic              last;

    assign last = (cnt == (wr_q ? WR_LAST : RD_LAST));

    // Transaction window counter, request capture and read sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act     <= 1'b0;
            wr_q    <= 1'b0;
            cnt     <= '0;
            addr_q  <= '0;
            data_q  <= '0;
            rd_data <= '0;
            fin     <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (!act) begin
                if (req) begin
                    act    <= 1'b1;
                    wr_q   <= req_wr;
                    addr_q <= req_addr;
                    data_q <= req_wr ? req_data : 8'h00;
                    cnt    <= '0;
                end
            end else if (last) begin
                act <= 1'b0;
                fin <= 1'b1;
                if (!wr_q) rd_data <= bus_rdata;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Bus pins: idle values outside a window, centred write strobe.
    always_comb begin
        bus_addr  = act ? addr_q : '0;
        bus_wdata = (act && wr_q) ? data_q : 8'h00;
        bus_we    = act && wr_q && (cnt != '0) && (cnt != WR_LAST);
        bus_re    = act && !wr_q;
    end

endmodule

// File: rtl/nor_erase_seq.sv
// Top: erase sequencer. On start it issues the six-write erase command
// (whole device or one sector), then polls toggle bit 6 with a sliding
// two-read comparison, honours timeout bit 5 with a final two-read recheck,
// and ends with a one-cycle done pulse and a pass/fail status byte.
// Assumes the flash returns steady read data while flash_re is high.
module nor_erase_seq
    import nor_erase_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int WR_CYC = 4,
    parameter int RD_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_sector,
    input  logic [ADDR_W-1:0] sector_addr,
    output logic              busy,
    output logic              done,
    output logic [7:0]        status,
    output logic [ADDR_W-1:0] flash_addr,
    output logic [7:0]        flash_wdata,
    output logic              flash_we,
    output logic              flash_re,
    input  logic [7:0]        flash_rdata
);

    localparam logic [2:0] LAST_STEP = 3'(NUM_STEPS - 1);

    seq_state_t        st;
    logic [2:0]        step;
    logic              op_q;
    logic [ADDR_W-1:0] sec_q;
    logic              req_q;
    logic [7:0]        prev_q;
    logic              done_q;
    logic [7:0]        status_q;

    logic [ADDR_W-1:0] cmd_addr;
    logic [7:0]        cmd_data;
    logic [ADDR_W-1:0] poll_addr;
    logic              fin;
    logic [7:0]        rd_data;
    logic              tgl_diff;

    nor_cmd_table #(.ADDR_W(ADDR_W)) u_table (
        .step      (step),
        .is_sector (op_q),
        .sec_addr  (sec_q),
        .cmd_addr  (cmd_addr),
        .cmd_data  (cmd_data)
    );

    assign poll_addr = op_q ? sec_q : ADDR_W'(KEY_ADDR_A);

    nor_bus_cycle #(.ADDR_W(ADDR_W), .WR_CYC(WR_CYC), .RD_CYC(RD_CYC)) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req_q),
        .req_wr    (st == ST_CMD),
        .req_addr  ((st == ST_CMD) ? cmd_addr : poll_addr),
        .req_data  (cmd_data),
        .fin       (fin),
        .rd_data   (rd_data),
        .bus_addr  (flash_addr),
        .bus_wdata (flash_wdata),
        .bus_we    (flash_we),
        .bus_re    (flash_re),
        .bus_rdata (flash_rdata)
    );

    assign tgl_diff = prev_q[TOGGLE_BIT] ^ rd_data[TOGGLE_BIT];

    // Sequencer: command steps, polling decisions and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            step     <= '0;
            op_q     <= 1'b0;
            sec_q    <= '0;
            req_q    <= 1'b0;
            prev_q   <= '0;
            done_q   <= 1'b0;
            status_q <= ST_PASS;
        end else begin
            req_q  <= 1'b0;
            done_q <= 1'b0;
            unique case (st)
                ST_IDLE: if (start) begin
                    op_q  <= op_sector;
                    sec_q <= sector_addr;
                    step  <= '0;
                    st    <= ST_CMD;
                    req_q <= 1'b1;
                end
                ST_CMD: if (fin) begin
                    req_q <= 1'b1;
                    if (step == LAST_STEP) st <= ST_PFIRST;
                    else                   step <= step + 1'b1;
                end
                ST_PFIRST: if (fin) begin
                    prev_q <= rd_data;
                    st     <= ST_POLL;
                    req_q  <= 1'b1;
                end
                ST_POLL: if (fin) begin
                    prev_q <= rd_data;
                    if (!tgl_diff) begin
                        st       <= ST_IDLE;
                        done_q   <= 1'b1;
                        status_q <= ST_PASS;
                    end else begin
                        req_q <= 1'b1;
                        if (rd_data[TMO_BIT]) st <= ST_RCHK_A;
                    end
                end
                ST_RCHK_A: if (fin) begin
                    prev_q <= rd_data;
                    st     <= ST_RCHK_B;
                    req_q  <= 1'b1;
                end
                ST_RCHK_B: if (fin) begin
                    st       <= ST_IDLE;
                    done_q   <= 1'b1;
                    status_q <= tgl_diff ? ST_FAIL : ST_PASS;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy   = (st != ST_IDLE);
    assign done   = done_q;
    assign status = status_q;

endmodule

// File: rtl/nor_erase_chk.sv
// Checker for nor_erase_seq: bus timing and handshake properties,
// attached to every instance of the top by the bind below.
module nor_erase_chk #(
    parameter int ADDR_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [7:0]        status,
    input logic [ADDR_W-1:0] flash_addr,
    input logic [7:0]        flash_wdata,
    input logic              flash_we,
    input logic              flash_re
);

    // R1: no bus activity while the block is idle.
    p_idle_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!flash_we && !flash_re));

    // R5: write strobe opens inside an already-stable address/data window.
    p_we_open_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flash_we) |-> ($stable(flash_addr) && $stable(flash_wdata)));

    // R5: write strobe closes while address/data are still held.
    p_we_close_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flash_we) |-> ($stable(flash_addr) && $stable(flash_wdata)));

    // R6: address steady throughout a read.
    p_re_addr_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_re && $past(flash_re)) |-> $stable(flash_addr));

    // R6: read and write strobes are exclusive.
    p_no_rw_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(flash_we && flash_re));

    // R10: done lasts one cycle.
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: done coincides with the fall of busy.
    p_done_at_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R10: status at done is one of the two legal codes.
    p_done_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (status == 8'h00 || status == 8'hFF));

    // R10: an accepted start raises busy on the next cycle.
    p_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R10: status holds between operations.
    p_status_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done) |-> $stable(status));

endmodule

bind nor_erase_seq nor_erase_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .status      (status),
    .flash_addr  (flash_addr),
    .flash_wdata (flash_wdata),
    .flash_we    (flash_we),
    .flash_re    (flash_re)
);

// File: tb/test_nor_erase_seq.sv
// Bench: sweeps device toggle length, timeout point and steady bit 5 for
// both operations; a behavioural flash model answers the status reads.
module test_nor_erase_seq;

    localparam int AW = 18;
    localparam int WR = 4;
    localparam int RD = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          op_sector = 1'b0;
    logic [AW-1:0] sector_addr = '0;
    logic          busy, done;
    logic [7:0]    status;
    logic [AW-1:0] flash_addr;
    logic [7:0]    flash_wdata;
    logic          flash_we, flash_re;
    logic [7:0]    flash_rdata;

    always #5 clk = ~clk;

    nor_erase_seq #(.ADDR_W(AW), .WR_CYC(WR), .RD_CYC(RD)) i_nor_erase_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sector(op_sector),
        .sector_addr(sector_addr), .busy(busy), .done(done), .status(status),
        .flash_addr(flash_addr), .flash_wdata(flash_wdata), .flash_we(flash_we),
        .flash_re(flash_re), .flash_rdata(flash_rdata)
    );

    int n_tests = 0;
    int n_fail  = 0;

    // Model configuration, written only by the stimulus.
    int            m_t = 1, m_k = 1;
    bit            m_s5 = 1'b0;
    logic [AW-1:0] m_paddr = '0;
    int            run_id = 0;

    // Model and monitor state, written only by the monitor.
    int            seen_id = 0;
    int            n_wr = 0, n_rd = 0, n_done = 0;
    int            bad_paddr = 0, bad_we_len = 0, bad_re_len = 0;
    logic [AW-1:0] wa [0:7];
    logic [7:0]    wd [0:7];
    logic [7:0]    done_status = 8'h00;
    bit            tg = 1'b0;
    bit            pwe = 1'b0, pre = 1'b0;
    int            we_len = 0, re_len = 0;

    // Flash status read value: toggle on bit 6, timeout flag on bit 5.
    always_comb begin
        flash_rdata = 8'hFF;
        flash_rdata[6] = tg;
        if (n_wr >= 6 && n_rd < m_t) flash_rdata[5] = (n_rd >= m_k);
        else                          flash_rdata[5] = m_s5;
    end

    // Monitor and device model, updated away from the active edge.
    always @(negedge clk) begin
        if (seen_id != run_id) begin
            seen_id = run_id;
            n_wr = 0; n_rd = 0; n_done = 0; tg = 1'b0;
            bad_paddr = 0; bad_we_len = 0; bad_re_len = 0;
        end
        if (flash_we && !pwe && n_wr < 8) begin
            wa[n_wr] = flash_addr; wd[n_wr] = flash_wdata;
        end
        if (flash_we) we_len++;
        if (!flash_we && pwe) begin
            if (we_len != WR - 2) bad_we_len++;
            we_len = 0;
            n_wr++;
        end
        if (flash_re) begin
            re_len++;
            if (flash_addr != m_paddr) bad_paddr++;
        end
        if (!flash_re && pre) begin
            if (re_len != RD) bad_re_len++;
            re_len = 0;
            if (n_wr >= 6 && n_rd < m_t) tg = ~tg;
            n_rd++;
        end
        if (done) begin n_done++; done_status = status; end
        pwe = flash_we; pre = flash_re;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One erase with the model set to toggle t reads, flag timeout at read k.
    task automatic run_one(input bit op, input logic [AW-1:0] sa, input int t,
                           input int k, input bit s5, input bit inject);
        int exp_reads;
        logic [7:0] exp_st;
        logic [AW-1:0] last_a;
        // Expected outcome from the device behaviour (k >= 1, t >= 1).
        if (k <= t - 1) begin
            exp_reads = k + 3;
            exp_st = (k == t - 1) ? 8'h00 : 8'hFF;
        end else begin
            exp_reads = s5 ? t + 3 : t + 2;
            exp_st = 8'h00;
        end
        last_a = op ? sa : AW'(16'h5555);
        @(negedge clk);
        #1;
        m_t = t; m_k = k; m_s5 = s5; m_paddr = last_a;
        run_id++;
        op_sector = op; sector_addr = sa; start = 1'b1;
        @(negedge clk);
        #1;
        start = 1'b0;
        chk(busy == 1'b1, "R10", "busy after start", int'(busy), 1);
        if (inject) begin
            repeat (9) @(negedge clk);
            #1;
            op_sector = ~op; sector_addr = ~sa; start = 1'b1;
            @(negedge clk);
            #1;
            start = 1'b0;
        end
        for (int i = 0; i < 3000 && n_done == 0; i++) @(negedge clk);
        repeat (4) @(negedge clk);
        #1;
        chk(n_done == 1, inject ? "R11" : "R10", "done pulses", n_done, 1);
        chk(busy == 1'b0, "R10", "busy after done", int'(busy), 0);
        chk(done_status == exp_st, (k <= t - 1) ? "R9" : "R8", "status",
            int'(done_status), int'(exp_st));
        chk(status == exp_st, "R10", "status held", int'(status), int'(exp_st));
        chk(n_rd == exp_reads, (k <= t - 1) ? "R9" : "R8", "read count",
            n_rd, exp_reads);
        chk(n_wr == 6, "R2", "write count", n_wr, 6);
        chk(wa[0] == AW'(16'h5555) && wd[0] == 8'hAA, "R2", "write0",
            int'(wd[0]), 8'hAA);
        chk(wa[1] == AW'(16'h2AAA) && wd[1] == 8'h55, "R2", "write1",
            int'(wd[1]), 8'h55);
        chk(wa[2] == AW'(16'h5555) && wd[2] == 8'h80, "R2", "write2",
            int'(wd[2]), 8'h80);
        chk(wa[3] == AW'(16'h5555) && wd[3] == 8'hAA, "R2", "write3",
            int'(wd[3]), 8'hAA);
        chk(wa[4] == AW'(16'h2AAA) && wd[4] == 8'h55, "R2", "write4",
            int'(wd[4]), 8'h55);
        if (op) begin
            chk(wa[5] == sa && wd[5] == 8'h30, inject ? "R11" : "R4",
                "sector command addr", int'(wa[5]), int'(sa));
        end else begin
            chk(wa[5] == AW'(16'h5555) && wd[5] == 8'h10, inject ? "R11" : "R3",
                "device command data", int'(wd[5]), 8'h10);
        end
        chk(bad_we_len == 0, "R5", "write strobe length errors", bad_we_len, 0);
        chk(bad_re_len == 0, "R6", "read strobe length errors", bad_re_len, 0);
        chk(bad_paddr == 0, "R7", "poll address errors", bad_paddr, 0);
    endtask

    int cyc = 0;
    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 150000", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        chk(!busy && !done && !flash_we && !flash_re, "R1", "idle pins",
            int'({busy, done, flash_we, flash_re}), 0);
        chk(status == 8'h00, "R1", "reset status", int'(status), 0);
        for (int t = 1; t <= 4; t++)
            for (int k = 1; k <= 5; k++)
                for (int s = 0; s <= 1; s++)
                    run_one(((t + k + s) % 2) == 1,
                            AW'((t * 18'h0_1357) ^ (k * 18'h0_2461) ^ (s << 17)),
                            t, k, s[0], 1'b0);
        // R11: start pulses while busy, both operations, pass and fail cases.
        run_one(1'b1, AW'(18'h2_4680), 3, 1, 1'b0, 1'b1);
        run_one(1'b0, AW'(18'h1_1111), 2, 4, 1'b1, 1'b1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule